// File: doc/BRIEF.md
# Four-Mode Timer/Counter Pair

This block holds two timer/counter units. Each unit has a low and a high count byte. One shared mode byte configures both units, one nibble per unit, and one shared control nibble holds both run bits and both overflow flags. A unit advances on a machine-cycle tick input, or on falling edges of its own count pin. Its run bit starts and stops it, and it can also be held off by its own gate pin.

Each unit has four modes:
- a 13-bit counter built from a 5-bit prescaler;
- a 16-bit counter;
- an 8-bit counter that reloads itself from the high byte;
- a split mode. In this mode unit 0 becomes two independent 8-bit counters, and the upper one borrows unit 1's run bit and overflow flag.

The count bytes are written and read through a small select port. An overflow sets a sticky flag. That flag is cleared by a control write or by a per-unit interrupt-acceptance clear input. Each unit also gives a one-cycle overflow pulse that a baud-rate generator can use.

Top module: `tmr_pair`

## Requirements
- R1: Mode bits 00 (bits [1:0] of a unit's nibble; unit 0 owns mode byte bits [3:0], unit 1 owns bits [7:4]) give a 13-bit counter. Each count adds one to the low byte's bits [4:0] and leaves its bits [7:5] unchanged. When bits [4:0] roll from 0x1F to 0, the high byte adds one. When the high byte rolls from 0xFF to 0, the unit overflows.
- R2: Mode bits 01 join the high and low bytes into one 16-bit up-counter. It overflows when it rolls over from 0xFFFF.
- R3: Mode bits 10 count in the low byte only. A count taken at 0xFF loads the low byte from the high byte and overflows.
- R4: Mode bits 11 on unit 0 split it into two counters:
  - Unit 0's low byte is an 8-bit counter that follows unit 0's controls and overflows into flag 0 and pulse 0.
  - Unit 0's high byte adds one on every tick cycle while run bit 1 is set. Its rollover from 0xFF sets flag 1 and gives no pulse.
  - While unit 0 is split, unit 1 still counts and pulses, but it does not set flag 1.
  - Unit 1 with mode bits 11 holds its count.
- R5: Nibble bit 3 is the gate bit. When it is set, the unit counts only while its gate pin is high. When it is clear, the run bit alone enables counting.
- R6: Nibble bit 2 selects the count source:
  - When the bit is set, the unit counts once for each cycle in which its count pin is low after being high on the previous clock edge.
  - When the bit is clear, the unit counts once for each cycle in which tick is high.
- R7: `cnt_sel` addresses the count bytes: bit 1 selects the unit and bit 0 selects the high byte. 0 is low 0, 1 is high 0, 2 is low 1 and 3 is high 1.
  - A write loads the addressed byte on the next edge and takes precedence over any increment or reload of that byte in the same cycle.
  - `rd_data` shows the byte addressed by `rd_sel` combinationally.
- R8: A control write loads the run bits from `ctl_wdata[1:0]` and the flags from `ctl_wdata[3:2]`. Without a control write:
  - a flag is set by its overflow;
  - otherwise it is cleared by its `flag_clr` bit;
  - otherwise it holds its value.
- R9: `ovf_pulse[u]` is high for exactly the one cycle after each clock edge at which unit u's own counter overflowed.
- R10: After reset, all count bytes, the mode byte, the run bits, the flags and the pulses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Machine-cycle count enable |
| cnt_pin | input | 2 | External count pins, one per unit |
| gate_pin | input | 2 | External gate pins, one per unit |
| mode_wr | input | 1 | Mode byte write strobe |
| mode_wdata | input | 8 | Mode byte data, one nibble per unit |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 4 | Run bits [1:0], flags [3:2] |
| flag_clr | input | 2 | Interrupt-acceptance flag clears |
| cnt_wr | input | 1 | Count byte write strobe |
| cnt_sel | input | 2 | Count byte write address |
| cnt_wdata | input | W | Count byte write data |
| rd_sel | input | 2 | Count byte read address |
| rd_data | output | W | Selected count byte |
| run | output | 2 | Run bits |
| flag | output | 2 | Overflow flags |
| ovf_pulse | output | 2 | One-cycle overflow pulses |

## Verification
Every counted cycle, reload, byte write, mode change and control write becomes visible one clock edge after the cycle in which it was presented: in the count bytes, the flags and the overflow pulses. Only `rd_data` follows `rd_sel` within the same cycle. A falling-edge count takes effect on the edge that follows the first cycle the pin reads low. The bench drives inputs just after the falling clock edge and advances its reference state once per rising edge. It compares every output at the next falling edge, so each result is checked in exactly the cycle it becomes due. The directed cases use literal values worked out from the rules above, for example the 0xFE→0xFF→reload walk in mode 10 and the simultaneous write-and-increment.

// File: rtl/tmr_pair.sv
module tmr_pair #(
  parameter int W   = 8,
  parameter int PRE = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [1:0]   cnt_pin,
  input  logic [1:0]   gate_pin,
  input  logic         mode_wr,
  input  logic [7:0]   mode_wdata,
  input  logic         ctl_wr,
  input  logic [3:0]   ctl_wdata,
  input  logic [1:0]   flag_clr,
  input  logic         cnt_wr,
  input  logic [1:0]   cnt_sel,
  input  logic [W-1:0] cnt_wdata,
  input  logic [1:0]   rd_sel,
  output logic [W-1:0] rd_data,
  output logic [1:0]   run,
  output logic [1:0]   flag,
  output logic [1:0]   ovf_pulse
);
  localparam int NB = 4;

  logic [7:0]   mode_q;
  logic [1:0]   pin_q;
  logic [W-1:0] lo [2];
  logic [W-1:0] hi [2];
  logic [W-1:0] lo_n [2];
  logic [W-1:0] hi_n [2];
  logic [1:0]   ovf, en;
  logic         hx_ovf;
  logic         split;

  assign split   = (mode_q[1:0] == 2'b11);
  assign rd_data = rd_sel[0] ? hi[rd_sel[1]] : lo[rd_sel[1]];

  always_comb begin
    for (int u = 0; u < 2; u++) begin
      en[u] = run[u] & (~mode_q[NB*u+3] | gate_pin[u]) &
              (mode_q[NB*u+2] ? (pin_q[u] & ~cnt_pin[u]) : tick);
      lo_n[u] = lo[u];
      hi_n[u] = hi[u];
      ovf[u]  = 1'b0;
      if (en[u]) begin
        case (mode_q[NB*u +: 2])
          2'b00: begin
            lo_n[u][PRE-1:0] = lo[u][PRE-1:0] + PRE'(1);
            if (&lo[u][PRE-1:0]) begin
              hi_n[u] = hi[u] + W'(1);
              ovf[u]  = &hi[u];
            end
          end
          2'b01: begin
            {hi_n[u], lo_n[u]} = {hi[u], lo[u]} + (2*W)'(1);
            ovf[u] = &{hi[u], lo[u]};
          end
          2'b10: begin
            if (&lo[u]) begin
              lo_n[u] = hi[u];
              ovf[u]  = 1'b1;
            end else begin
              lo_n[u] = lo[u] + W'(1);
            end
          end
          default: begin
            if (u == 0) begin
              lo_n[u] = lo[u] + W'(1);
              ovf[u]  = &lo[u];
            end
          end
        endcase
      end
    end
    hx_ovf = 1'b0;
    if (split && run[1] && tick) begin
      hi_n[0] = hi[0] + W'(1);
      hx_ovf  = &hi[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= '0;
      pin_q     <= '0;
      run       <= '0;
      flag      <= '0;
      ovf_pulse <= '0;
      for (int u = 0; u < 2; u++) begin
        lo[u] <= '0;
        hi[u] <= '0;
      end
    end else begin
      pin_q     <= cnt_pin;
      ovf_pulse <= ovf;
      if (mode_wr) mode_q <= mode_wdata;
      if (ctl_wr) begin
        run  <= ctl_wdata[1:0];
        flag <= ctl_wdata[3:2];
      end else begin
        flag <= (flag & ~flag_clr) | {split ? hx_ovf : ovf[1], ovf[0]};
      end
      for (int u = 0; u < 2; u++) begin
        lo[u] <= (cnt_wr && cnt_sel[1] == u[0] && !cnt_sel[0]) ? cnt_wdata : lo_n[u];
        hi[u] <= (cnt_wr && cnt_sel[1] == u[0] &&  cnt_sel[0]) ? cnt_wdata : hi_n[u];
      end
    end
  end
endmodule

module tmr_pair_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ctl_wr,
  input logic [3:0]   ctl_wdata,
  input logic [1:0]   flag_clr,
  input logic         cnt_wr,
  input logic [1:0]   cnt_sel,
  input logic [W-1:0] cnt_wdata,
  input logic [1:0]   run,
  input logic [1:0]   flag,
  input logic [1:0]   ovf_pulse,
  input logic [W-1:0] lo0,
  input logic [W-1:0] hi0,
  input logic [W-1:0] lo1,
  input logic [W-1:0] hi1
);
  // R7
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && cnt_sel == 2'd0) |=> (lo0 == $past(cnt_wdata)));

  // R8
  ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (flag == $past(ctl_wdata[3:2]) && run == $past(ctl_wdata[1:0])));

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag[0]) |-> ($past(ctl_wr) || $past(flag_clr[0])));

  // R9
  pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pulse[0] && !$past(ctl_wr)) |-> flag[0]);

  // R5
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run == 2'b00 && !cnt_wr) |=> ($stable(lo0) && $stable(hi0) && $stable(lo1) && $stable(hi1)));
endmodule

bind tmr_pair tmr_pair_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .flag_clr(flag_clr), .cnt_wr(cnt_wr), .cnt_sel(cnt_sel), .cnt_wdata(cnt_wdata),
  .run(run), .flag(flag), .ovf_pulse(ovf_pulse),
  .lo0(lo[0]), .hi0(hi[0]), .lo1(lo[1]), .hi1(hi[1])
);

// File: tb/tmr_pair_test.sv
`timescale 1ns/1ps
module tmr_pair_test;
  logic clk = 0, rst_n = 0;
  logic tick = 0, mode_wr = 0, ctl_wr = 0, cnt_wr = 0;
  logic [1:0] cnt_pin = 0, gate_pin = 0, flag_clr = 0, cnt_sel = 0, rd_sel = 0;
  logic [7:0] mode_wdata = 0, cnt_wdata = 0;
  logic [3:0] ctl_wdata = 0;
  logic [7:0] rd_data;
  logic [1:0] run, flag, ovf_pulse;

  int n_chk = 0, n_bad = 0;

  logic [7:0] mlo [2];
  logic [7:0] mhi [2];
  logic [7:0] mmode;
  logic [1:0] mrun, mflag, mpulse, mpin;

  always #2.5 clk = ~clk;

  tmr_pair uut (.*);

  task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  function automatic void mreset();
    for (int u = 0; u < 2; u++) begin mlo[u] = 0; mhi[u] = 0; end
    mmode = 0; mrun = 0; mflag = 0; mpulse = 0; mpin = 0;
  endfunction

  function automatic void mstep();
    logic [7:0] nlo [2];
    logic [7:0] nhi [2];
    logic [1:0] ov;
    logic hx;
    logic [15:0] c16;
    ov = 0; hx = 0;
    for (int u = 0; u < 2; u++) begin
      logic [3:0] nib;
      logic ev, en;
      nib = mmode[4*u +: 4];
      nlo[u] = mlo[u]; nhi[u] = mhi[u];
      ev = nib[2] ? (mpin[u] && !cnt_pin[u]) : tick;
      en = mrun[u] && (!nib[3] || gate_pin[u]) && ev;
      if (en) begin
        case (nib[1:0])
          2'd0: if (mlo[u][4:0] == 5'h1F) begin
                  nlo[u] = mlo[u] & 8'hE0; nhi[u] = mhi[u] + 1; ov[u] = (mhi[u] == 8'hFF);
                end else nlo[u] = mlo[u] + 1;
          2'd1: begin
                  c16 = {mhi[u], mlo[u]} + 16'd1;
                  nhi[u] = c16[15:8]; nlo[u] = c16[7:0]; ov[u] = (c16 == 16'd0);
                end
          2'd2: if (mlo[u] == 8'hFF) begin nlo[u] = mhi[u]; ov[u] = 1; end
                else nlo[u] = mlo[u] + 1;
          default: if (u == 0) begin nlo[u] = mlo[u] + 1; ov[u] = (mlo[u] == 8'hFF); end
        endcase
      end
    end
    if (mmode[1:0] == 2'd3 && mrun[1] && tick) begin
      nhi[0] = mhi[0] + 1; hx = (mhi[0] == 8'hFF);
    end
    if (cnt_wr) begin
      if (cnt_sel[0]) nhi[cnt_sel[1]] = cnt_wdata;
      else            nlo[cnt_sel[1]] = cnt_wdata;
    end
    if (ctl_wr) begin mrun = ctl_wdata[1:0]; mflag = ctl_wdata[3:2]; end
    else begin
      mflag[0] = ov[0] ? 1'b1 : (mflag[0] & ~flag_clr[0]);
      mflag[1] = ((mmode[1:0] == 2'd3) ? hx : ov[1]) ? 1'b1 : (mflag[1] & ~flag_clr[1]);
    end
    mpulse = ov;
    mpin = cnt_pin;
    if (mode_wr) mmode = mode_wdata;
    for (int u = 0; u < 2; u++) begin mlo[u] = nlo[u]; mhi[u] = nhi[u]; end
  endfunction

  function automatic string byte_req(logic [1:0] s);
    logic [1:0] m;
    m = mmode[4*s[1] +: 2];
    if (mmode[1:0] == 2'd3 && s == 2'd1) return "R4";
    case (m)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic step();
    mstep();
    @(negedge clk);
    chk("R8 flag", {6'd0, flag}, {6'd0, mflag});
    chk("R8 run", {6'd0, run}, {6'd0, mrun});
    chk("R9 pulse", {6'd0, ovf_pulse}, {6'd0, mpulse});
    chk({byte_req(rd_sel), " byte"}, rd_data, rd_sel[0] ? mhi[rd_sel[1]] : mlo[rd_sel[1]]);
  endtask

  task automatic idle();
    tick = 0; mode_wr = 0; ctl_wr = 0; cnt_wr = 0; flag_clr = 0;
  endtask

  task automatic peek(string r, logic [1:0] s, logic [7:0] exp);
    rd_sel = s; #0.5;
    chk(r, rd_data, exp);
  endtask

  task automatic wbyte(logic [1:0] s, logic [7:0] d);
    idle(); cnt_wr = 1; cnt_sel = s; cnt_wdata = d; step(); cnt_wr = 0;
  endtask

  task automatic setmode(logic [7:0] m, logic [3:0] c);
    idle(); mode_wr = 1; mode_wdata = m; ctl_wr = 1; ctl_wdata = c; step(); idle();
  endtask

  task automatic do_reset();
    rst_n = 0; idle(); cnt_pin = 0; gate_pin = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1; mreset();
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd41));
    do_reset();
    // R10 reset state
    for (int s = 0; s < 4; s++) peek("R10 reset byte", 2'(s), 8'h00);
    chk("R10 flags", {6'd0, flag}, 8'h00);
    chk("R10 pulse", {6'd0, ovf_pulse}, 8'h00);
    chk("R10 run", {6'd0, run}, 8'h00);

    // R3 reload walk
    wbyte(2'd1, 8'h80); wbyte(2'd0, 8'hFE);
    setmode(8'h02, 4'b0001);
    tick = 1; step(); step(); tick = 0;
    peek("R3 reload", 2'd0, 8'h80);
    chk("R8 flag set", {7'd0, flag[0]}, 8'h01);
    chk("R9 pulse high", {7'd0, ovf_pulse[0]}, 8'h01);
    step();
    chk("R9 pulse single", {7'd0, ovf_pulse[0]}, 8'h00);
    flag_clr = 2'b01; step(); flag_clr = 0;
    chk("R8 flag clear", {7'd0, flag[0]}, 8'h00);

    // R1 prescaler carry
    setmode(8'h00, 4'b0001);
    wbyte(2'd0, 8'hFF); wbyte(2'd1, 8'h12);
    tick = 1; step(); tick = 0;
    peek("R1 low", 2'd0, 8'hE0);
    peek("R1 high", 2'd1, 8'h13);

    // R7 write beats increment
    setmode(8'h01, 4'b0001);
    wbyte(2'd0, 8'h10);
    tick = 1; cnt_wr = 1; cnt_sel = 0; cnt_wdata = 8'h55; step(); idle();
    peek("R7 write wins", 2'd0, 8'h55);

    // R5 gating
    setmode(8'h09, 4'b0001);
    gate_pin = 0; tick = 1; step(); step(); step();
    peek("R5 gated off", 2'd0, 8'h55);
    gate_pin = 2'b01; step(); step(); tick = 0;
    peek("R5 gated on", 2'd0, 8'h57);

    // R6 falling edge counting
    setmode(8'h05, 4'b0001);
    cnt_pin = 2'b01; step(); step();
    cnt_pin = 2'b00; step(); step(); step();
    peek("R6 one edge", 2'd0, 8'h58);

    // R4 split mode
    setmode(8'h03, 4'b0011);
    wbyte(2'd0, 8'hFF); wbyte(2'd1, 8'hFF);
    tick = 1; step(); tick = 0;
    peek("R4 low wrap", 2'd0, 8'h00);
    peek("R4 high wrap", 2'd1, 8'h00);
    chk("R4 flags", {6'd0, flag}, 8'h03);
    chk("R4 pulses", {6'd0, ovf_pulse}, 8'h01);

    // R2 random mixed phase
    do_reset();
    for (int i = 0; i < 6000; i++) begin
      idle();
      tick = 1'($urandom);
      if ($urandom % 4 == 0) cnt_pin = 2'($urandom);
      if ($urandom % 6 == 0) gate_pin = 2'($urandom);
      if ($urandom % 300 == 0) begin mode_wr = 1; mode_wdata = 8'($urandom); end
      if ($urandom % 60 == 0) begin ctl_wr = 1; ctl_wdata = 4'($urandom) | 4'b0011; end
      if ($urandom % 9 == 0) flag_clr = 2'($urandom);
      if ($urandom % 12 == 0) begin
        cnt_wr = 1; cnt_sel = 2'($urandom);
        case ($urandom % 4)
          0: cnt_wdata = 8'hFF;
          1: cnt_wdata = 8'h1F;
          2: cnt_wdata = 8'hFE;
          default: cnt_wdata = 8'($urandom);
        endcase
      end
      rd_sel = 2'($urandom);
      step();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule